// File: doc/BRIEF.md
# Byte-Load Strobe Qualifier

This block sits behind the asynchronous parallel pins of a byte-wide nonvolatile memory. It turns the raw active-low chip-select, write and read-enable pins into clean byte-load events in the system clock domain. The pins first pass through a configurable synchronizer. Inside, the block forms one write strobe that is active only while both chip-select and write are low. It takes the address when that strobe turns on, which is the later of the two falling edges. It takes the data when the strobe turns off, which is the earlier of the two rising edges.

A load is only released when several conditions hold:
- the read-enable pin stayed high for the whole strobe;
- the strobe lasted at least a minimum number of sampled clocks, which rejects glitches;
- the supply-good input reports a healthy supply;
- a power-on hold-off has run out since the supply became good, or since the last reset.

A released load appears as a one-cycle pulse with the address and data that were taken.

Top module: `wq_strobe_qual`

## Requirements
- R1: After reset `load_valid` is low and `load_addr` and `load_data` are zero.
- R2: A low pulse on `we_n` while `ce_n` is low and `oe_n` is high, once powered, produces exactly one load.
- R3: A low pulse on `ce_n` while `we_n` is low and `oe_n` is high, once powered, produces exactly one load.
- R4: `load_addr` is the address present when the later of the two pins fell. Address changes made while the strobe is active have no effect.
- R5: `load_data` is the data present when the earlier of the two pins rose. Data changes made after that have no effect.
- R6: If `oe_n` is low at any sampled clock while the strobe is active, no load occurs.
- R7: A strobe active for fewer than MIN_PULSE sampled clocks gives no load. A strobe lasting MIN_PULSE clocks or more gives one load.
- R8: While `vcc_ok` is low, no load occurs.
- R9: After `vcc_ok` rises, loads stay blocked for PON_CYCLES clocks plus synchronizer latency.
- R10: Asserting `rst_n` low restarts the power-on hold-off.
- R11: `load_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip-select pin, active low, asynchronous |
| we_n | input | 1 | Write pin, active low, asynchronous |
| oe_n | input | 1 | Read-enable pin, active low, asynchronous |
| vcc_ok | input | 1 | Supply-good sense, high when supply is healthy |
| addr_in | input | ADDR_W | Address bus pins |
| data_in | input | DATA_W | Data bus pins |
| load_valid | output | 1 | One-cycle pulse marking a qualified byte load |
| load_addr | output | ADDR_W | Address of the load |
| load_data | output | DATA_W | Data byte of the load |

## Verification
The bench builds the block with MIN_PULSE = 3, PON_CYCLES = 20 and two synchronizer stages. The short filter lets a sweep of strobe widths from 1 to 6 clocks cover both sides of the glitch threshold, for both pin orders. The short hold-off lets loads be tried inside the blocked window, after brown-out and after reset, and then succeed, all within a few hundred cycles.

// File: rtl/wq_pkg.sv
package wq_pkg;
   localparam int unsigned WQ_ADDR_W_DEF = 16;
   localparam int unsigned WQ_DATA_W_DEF = 8;
   localparam int unsigned WQ_SYNC_MIN   = 2;
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
   parameter int unsigned W          = 1,
   parameter int unsigned STAGES     = 2,
   parameter logic [W-1:0] RST_VAL   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   initial assert (STAGES >= wq_pkg::WQ_SYNC_MIN) else $error("wq_sync: STAGES too small");

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wq_pwr_gate.sv
module wq_pwr_gate #(
   parameter int unsigned PON_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_s,
   output logic en
);
   localparam int unsigned CW = $clog2(PON_CYCLES + 1);

   logic [CW-1:0] cnt;
   logic          ready;

   initial assert (PON_CYCLES >= 1) else $error("wq_pwr_gate: PON_CYCLES must be at least 1");

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt   <= '0;
         ready <= 1'b0;
      end else if (!vcc_s) begin
         cnt   <= '0;
         ready <= 1'b0;
      end else if (cnt == CW'(PON_CYCLES)) begin
         ready <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end

   assign en = ready && vcc_s;

   // R8: a supply drop withdraws readiness on the next cycle
   assert_brownout_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vcc_s) |=> !ready);
endmodule

// File: rtl/wq_strobe_filter.sv
module wq_strobe_filter #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MIN_PULSE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              we_s,
   input  logic              oe_s,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              load_valid,
   output logic [ADDR_W-1:0] load_addr,
   output logic [DATA_W-1:0] load_data
);
   localparam int unsigned CW = $clog2(MIN_PULSE + 1);

   logic              stb_raw, stb_q, rise, fall, armed;
   logic [CW-1:0]     wid;
   logic [ADDR_W-1:0] addr_hold;

   initial assert (MIN_PULSE >= 1) else $error("wq_strobe_filter: MIN_PULSE must be at least 1");

   assign stb_raw = !ce_s && !we_s;
   assign rise    = stb_raw && !stb_q;
   assign fall    = !stb_raw && stb_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         stb_q      <= 1'b0;
         armed      <= 1'b0;
         wid        <= '0;
         addr_hold  <= '0;
         load_valid <= 1'b0;
         load_addr  <= '0;
         load_data  <= '0;
      end else begin
         stb_q      <= stb_raw;
         load_valid <= 1'b0;
         if (rise) begin
            addr_hold <= addr_in;
            wid       <= CW'(1);
            armed     <= oe_s && en;
         end else if (stb_raw) begin
            if (wid != CW'(MIN_PULSE)) wid <= wid + 1'b1;
            if (!oe_s || !en) armed <= 1'b0;
         end else if (fall) begin
            if (armed && en && (wid == CW'(MIN_PULSE))) begin
               load_valid <= 1'b1;
               load_addr  <= addr_hold;
               load_data  <= data_in;
            end
            armed <= 1'b0;
         end
      end

   // R11: a load pulse lasts one cycle
   assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |=> !load_valid);

   // R2: a load only follows the end of a strobe
   assert_load_after_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |-> $past(stb_q && !stb_raw));

   // R9: a load only issues while the power gate allowed it
   assert_load_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |-> $past(en));
endmodule

// File: rtl/wq_strobe_qual.sv
module wq_strobe_qual #(
   parameter int unsigned ADDR_W      = wq_pkg::WQ_ADDR_W_DEF,
   parameter int unsigned DATA_W      = wq_pkg::WQ_DATA_W_DEF,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_PULSE   = 2,
   parameter int unsigned PON_CYCLES  = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              vcc_ok,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              load_valid,
   output logic [ADDR_W-1:0] load_addr,
   output logic [DATA_W-1:0] load_data
);
   logic [2:0] pins_s;
   logic       vcc_s, en;

   initial assert (ADDR_W >= 1 && DATA_W >= 1) else $error("wq_strobe_qual: bad bus width");

   wq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d({oe_n, we_n, ce_n}), .q(pins_s));

   wq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vcc_sync (
      .clk(clk), .rst_n(rst_n), .d(vcc_ok), .q(vcc_s));

   wq_pwr_gate #(.PON_CYCLES(PON_CYCLES)) u_pwr (
      .clk(clk), .rst_n(rst_n), .vcc_s(vcc_s), .en(en));

   wq_strobe_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_filt (
      .clk(clk), .rst_n(rst_n),
      .ce_s(pins_s[0]), .we_s(pins_s[1]), .oe_s(pins_s[2]), .en(en),
      .addr_in(addr_in), .data_in(data_in),
      .load_valid(load_valid), .load_addr(load_addr), .load_data(load_data));

   // R8: with the synchronized supply low, no load appears
   assert_no_load_low_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc_s |=> !load_valid);
endmodule

// File: tb/test_wq_strobe_qual.sv
`timescale 1ns/1ps
module test_wq_strobe_qual;
   localparam int AW = 16, DW = 8, MINP = 3, PON = 20;

   logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1, vcc_ok = 0;
   logic [AW-1:0] addr_in = '0;
   logic [DW-1:0] data_in = '0;
   logic load_valid;
   logic [AW-1:0] load_addr;
   logic [DW-1:0] load_data;

   int checks = 0, errors = 0, nloads = 0;
   logic [AW-1:0] last_a;
   logic [DW-1:0] last_d;
   logic prev_v = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wq_strobe_qual #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .MIN_PULSE(MINP), .PON_CYCLES(PON))
      i_wq_strobe_qual (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
         .vcc_ok(vcc_ok), .addr_in(addr_in), .data_in(data_in),
         .load_valid(load_valid), .load_addr(load_addr), .load_data(load_data));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor at the falling edge; R11 width check
   always @(negedge clk) begin
      if (load_valid) begin
         nloads++;
         last_a = load_addr;
         last_d = load_data;
         if (prev_v) check("R11 back-to-back load_valid", 1, 0);
      end
      prev_v = load_valid;
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // mode 0: pulse we_n with ce_n low; mode 1: pulse ce_n with we_n low
   task automatic pulse(input int mode, input int width, input int a, input int d);
      addr_in = AW'(a); data_in = DW'(d);
      if (mode == 0) ce_n = 0; else we_n = 0;
      idle(1);
      if (mode == 0) we_n = 0; else ce_n = 0;
      idle(width);
      if (mode == 0) we_n = 1; else ce_n = 1;
      idle(6);
      ce_n = 1; we_n = 1;
      idle(3);
   endtask

   initial begin
      int n0;
      idle(3);
      check("R1 load_valid after reset", int'(load_valid), 0);
      check("R1 load_addr after reset", int'(load_addr), 0);
      check("R1 load_data after reset", int'(load_data), 0);
      rst_n = 1;
      vcc_ok = 1;
      idle(PON + 10);

      // R2/R3/R7 sweep over widths and pin orders
      for (int m = 0; m < 2; m++) begin
         for (int w = 1; w <= 6; w++) begin
            n0 = nloads;
            pulse(m, w, w * 37 + m * 1000, w * 5 + m * 100);
            check(m == 0 ? "R2/R7 load count (we pulse)" : "R3/R7 load count (ce pulse)",
                  nloads - n0, (w >= MINP) ? 1 : 0);
            if (w >= MINP) begin
               check("R2 R3 address", int'(last_a), w * 37 + m * 1000);
               check("R2 R3 data", int'(last_d), (w * 5 + m * 100) & 8'hFF);
            end
         end
      end

      // R4: address from the later fall, not changed by later addr moves
      n0 = nloads;
      addr_in = 16'h1111; data_in = 8'h5A; ce_n = 0;
      idle(3);
      addr_in = 16'hBEEF; we_n = 0;
      idle(5);
      addr_in = 16'h2222;
      idle(2);
      we_n = 1; idle(6); ce_n = 1; idle(3);
      check("R4 load count", nloads - n0, 1);
      check("R4 address from later fall", int'(last_a), 16'hBEEF);

      // R5: data from the earlier rise
      n0 = nloads;
      addr_in = 16'h0404; data_in = 8'hC3; ce_n = 0; we_n = 0;
      idle(5);
      we_n = 1;
      idle(5);
      data_in = 8'h3C;
      idle(3);
      ce_n = 1; idle(6);
      check("R5 load count", nloads - n0, 1);
      check("R5 data from earlier rise", int'(last_d), 8'hC3);

      // R6: oe_n low through the pulse, then low mid-pulse
      n0 = nloads;
      oe_n = 0; pulse(0, 5, 16'h0606, 8'h66); oe_n = 1; idle(3);
      check("R6 oe low whole pulse", nloads - n0, 0);
      n0 = nloads;
      ce_n = 0; idle(1); we_n = 0; idle(3); oe_n = 0; idle(2); oe_n = 1; idle(3);
      we_n = 1; idle(6); ce_n = 1; idle(3);
      check("R6 oe low mid pulse", nloads - n0, 0);

      // R8: supply low
      n0 = nloads;
      vcc_ok = 0; idle(5);
      pulse(0, 5, 16'h0808, 8'h88);
      check("R8 low supply blocks", nloads - n0, 0);

      // R9: inside hold-off, then after
      vcc_ok = 1; idle(2);
      n0 = nloads;
      pulse(1, 4, 16'h0909, 8'h99);
      check("R9 within hold-off", nloads - n0, 0);
      idle(PON + 10);
      n0 = nloads;
      pulse(1, 4, 16'h0A0A, 8'hAA);
      check("R9 after hold-off", nloads - n0, 1);
      check("R9 address", int'(last_a), 16'h0A0A);

      // R10: reset restarts the hold-off
      rst_n = 0; idle(2); rst_n = 1; idle(2);
      n0 = nloads;
      pulse(0, 4, 16'h1010, 8'h10);
      check("R10 blocked after reset", nloads - n0, 0);
      idle(PON + 10);
      n0 = nloads;
      pulse(0, 4, 16'h1011, 8'h11);
      check("R10 allowed after hold-off", nloads - n0, 1);
      check("R10 data", int'(last_d), 8'h11);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired (R1..) actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule